// File: doc/BRIEF.md
# Subwarp-Partitioned Load Coalescer

This block turns one warp-wide load into a short stream of memory-block requests. A warp of 32 threads hands over, in a single valid/ready transfer, one byte address for each thread, an active mask and a 5-bit subwarp id for each thread. Each memory block is 4 bytes, so a thread's block address is its byte address with the two low bits removed. Threads are merged into one request only when they have the same block address and the same subwarp id. If two subwarps touch the same block, they still produce two separate requests.

The subwarps are served in ascending id order. Inside a subwarp, the lowest-numbered thread that is still unserved is the leader. Each request carries the leader's block address, the subwarp id and a mask of every thread that the request serves. Each request is offered with a valid/ready handshake, and one request is emitted per cycle when the consumer is ready. After the last request is taken, a one-cycle done pulse presents the exact number of requests issued for the warp. The number must be exact because the request count sets the memory-side time of the load. The block does not choose the subwarp ids, and it knows nothing of caches or DRAM.

Top module: `swp_coalescer`

## Requirements
- R1: `in_ready` is 1 only while no warp is in progress. A warp is accepted on a cycle where `in_valid` and `in_ready` are both 1. `in_ready` and `req_valid` are never 1 together.
- R2: A request's `req_blk` equals the leader thread's byte address shifted right by 2 (4-byte blocks).
- R3: Active threads that share a subwarp id and a block address are served by one request. Its `req_mask` has bit i set for each thread i that it serves, and it is never empty.
- R4: Threads with different subwarp ids are never in the same request. For example, addresses 0x00, 0x04, 0x07, 0x09 on threads 0..3 give 3 requests with one subwarp id and 4 requests with ids 0,0,1,1.
- R5: Threads whose `in_mask` bit is 0 never appear in any request.
- R6: Requests come out in ascending subwarp id order. Within one id, they follow the ascending index of the lowest unserved thread.
- R7: While `req_valid` is 1 and `req_ready` is 0, `req_blk`, `req_sid` and `req_mask` hold their values.
- R8: `done` is 1 for exactly one cycle, the cycle after the last request handshake. In that cycle `done_count` equals the number of requests issued for the warp. A warp with no active thread gives `done` two cycles after acceptance, with count 0.
- R9: Each active thread is served by exactly one request of its warp.
- R10: After reset, `in_ready` is 1 and `req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Warp load offered |
| in_ready | output | 1 | Block can accept a warp |
| in_addr | input | 1024 | Byte address of thread i in bits [32i+31:32i] |
| in_sid | input | 160 | Subwarp id of thread i in bits [5i+4:5i] |
| in_mask | input | 32 | Active thread mask, bit i for thread i |
| req_valid | output | 1 | Block request offered |
| req_ready | input | 1 | Consumer takes the request |
| req_blk | output | 30 | Block address of the request |
| req_sid | output | 5 | Subwarp id of the request |
| req_mask | output | 32 | Threads served by the request |
| done | output | 1 | One-cycle pulse after the last request |
| done_count | output | 6 | Number of requests issued for the warp |

## Verification
Unserved threads are held in a pending mask. A bit wrongly left set shows up as an extra request, a higher `done_count` and a late `done`. A bit wrongly cleared shows up as a missing thread in some `req_mask` and a lower count. Because the reference compares every request at its handshake, a wrong subwarp choice or leader choice shows up on the first request that differs. A wrong merge shows up the same way, as a mismatched block, id or mask. A fault in the handshake or in the count shows up in the cycle in which `done` or `in_ready` should change.

// File: rtl/swc_pkg.sv
package swc_pkg;
    localparam int DEF_THREADS = 32;
    localparam int DEF_ADDR_W  = 32;
    localparam int DEF_SID_W   = 5;
    localparam int DEF_BLK_OFS = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } coal_state_e;
endpackage

// File: rtl/swc_min_sid.sv
module swc_min_sid #(
    parameter int NUM_THR = 32,
    parameter int SID_W   = 5
) (
    input  logic [NUM_THR-1:0]       pend,
    input  logic [NUM_THR*SID_W-1:0] sid_flat,
    output logic [SID_W-1:0]         min_sid,
    output logic                     any
);
    always_comb begin
        min_sid = '1;
        any     = 1'b0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (pend[i] && (!any || sid_flat[i*SID_W +: SID_W] < min_sid)) begin
                min_sid = sid_flat[i*SID_W +: SID_W];
                any     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/swc_leader.sv
module swc_leader #(
    parameter int NUM_THR = 32,
    parameter int SID_W   = 5,
    localparam int TID_W  = $clog2(NUM_THR)
) (
    input  logic [NUM_THR-1:0]       pend,
    input  logic [NUM_THR*SID_W-1:0] sid_flat,
    input  logic [SID_W-1:0]         cur_sid,
    output logic [TID_W-1:0]         lead,
    output logic                     found
);
    always_comb begin
        lead  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (!found && pend[i] && sid_flat[i*SID_W +: SID_W] == cur_sid) begin
                lead  = TID_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/swc_match.sv
module swc_match #(
    parameter int NUM_THR = 32,
    parameter int SID_W   = 5,
    parameter int BLK_W   = 30
) (
    input  logic [NUM_THR-1:0]       pend,
    input  logic [NUM_THR*SID_W-1:0] sid_flat,
    input  logic [NUM_THR*BLK_W-1:0] blk_flat,
    input  logic [SID_W-1:0]         cur_sid,
    input  logic [BLK_W-1:0]         lead_blk,
    output logic [NUM_THR-1:0]       hit
);
    for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
        assign hit[g] = pend[g]
                     && (sid_flat[g*SID_W +: SID_W] == cur_sid)
                     && (blk_flat[g*BLK_W +: BLK_W] == lead_blk);
    end
endmodule

// File: rtl/swp_coalescer.sv
module swp_coalescer
    import swc_pkg::*;
#(
    parameter int NUM_THR = DEF_THREADS,
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int SID_W   = DEF_SID_W,
    parameter int BLK_OFS = DEF_BLK_OFS,
    localparam int BLK_W  = ADDR_W - BLK_OFS,
    localparam int CNT_W  = $clog2(NUM_THR + 1),
    localparam int TID_W  = $clog2(NUM_THR)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [NUM_THR*ADDR_W-1:0] in_addr,
    input  logic [NUM_THR*SID_W-1:0]  in_sid,
    input  logic [NUM_THR-1:0]        in_mask,
    output logic                      req_valid,
    input  logic                      req_ready,
    output logic [BLK_W-1:0]          req_blk,
    output logic [SID_W-1:0]          req_sid,
    output logic [NUM_THR-1:0]        req_mask,
    output logic                      done,
    output logic [CNT_W-1:0]          done_count
);
    coal_state_e               state_q;
    logic [NUM_THR-1:0]        pend_q;
    logic [NUM_THR*BLK_W-1:0]  blk_q;
    logic [NUM_THR*SID_W-1:0]  sid_q;
    logic [CNT_W-1:0]          cnt_q;
    logic                      done_q;

    logic [SID_W-1:0]          cur_sid;
    logic                      any_pend;
    logic [TID_W-1:0]          lead;
    logic                      lead_found;
    logic [BLK_W-1:0]          lead_blk;
    logic [NUM_THR-1:0]        hit;
    logic                      fire;
    logic [NUM_THR-1:0]        pend_nx;

    swc_min_sid #(.NUM_THR(NUM_THR), .SID_W(SID_W)) u_min (
        .pend(pend_q), .sid_flat(sid_q), .min_sid(cur_sid), .any(any_pend)
    );

    swc_leader #(.NUM_THR(NUM_THR), .SID_W(SID_W)) u_lead (
        .pend(pend_q), .sid_flat(sid_q), .cur_sid(cur_sid),
        .lead(lead), .found(lead_found)
    );

    assign lead_blk = blk_q[lead*BLK_W +: BLK_W];

    swc_match #(.NUM_THR(NUM_THR), .SID_W(SID_W), .BLK_W(BLK_W)) u_match (
        .pend(pend_q), .sid_flat(sid_q), .blk_flat(blk_q),
        .cur_sid(cur_sid), .lead_blk(lead_blk), .hit(hit)
    );

    assign in_ready   = (state_q == ST_IDLE);
    assign req_valid  = (state_q == ST_RUN) && any_pend && lead_found;
    assign req_blk    = lead_blk;
    assign req_sid    = cur_sid;
    assign req_mask   = hit;
    assign done       = done_q;
    assign done_count = cnt_q;

    assign fire    = req_valid && req_ready;
    assign pend_nx = fire ? (pend_q & ~hit) : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            blk_q   <= '0;
            sid_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        for (int i = 0; i < NUM_THR; i++) begin
                            blk_q[i*BLK_W +: BLK_W] <= in_addr[i*ADDR_W + BLK_OFS +: BLK_W];
                        end
                        sid_q   <= in_sid;
                        pend_q  <= in_mask;
                        cnt_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    pend_q <= pend_nx;
                    if (fire) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (pend_nx == '0) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
    parameter int NUM_THR = 32,
    parameter int SID_W   = 5,
    parameter int BLK_W   = 30
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic [NUM_THR*SID_W-1:0] in_sid,
    input logic [NUM_THR-1:0]       in_mask,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [BLK_W-1:0]         req_blk,
    input logic [SID_W-1:0]         req_sid,
    input logic [NUM_THR-1:0]       req_mask,
    input logic                     done
);
    logic [NUM_THR-1:0]       cap_mask;
    logic [NUM_THR*SID_W-1:0] cap_sid;
    logic [NUM_THR-1:0]       served;
    logic [SID_W-1:0]         last_sid;
    logic                     have_last;
    logic [NUM_THR-1:0]       sid_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_mask  <= '0;
            cap_sid   <= '0;
            served    <= '0;
            last_sid  <= '0;
            have_last <= 1'b0;
        end else if (in_valid && in_ready) begin
            cap_mask  <= in_mask;
            cap_sid   <= in_sid;
            served    <= '0;
            have_last <= 1'b0;
        end else if (req_valid && req_ready) begin
            served    <= served | req_mask;
            last_sid  <= req_sid;
            have_last <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_THR; g++) begin : g_sid
        assign sid_ok[g] = !req_mask[g] || (cap_sid[g*SID_W +: SID_W] == req_sid);
    end

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !in_ready);                                        // R1
    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_mask != '0));                                 // R3
    AST_SID_MATCH: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (&sid_ok));                                        // R4
    AST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_mask & ~cap_mask) == '0));                   // R5
    AST_SID_ORDER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && have_last) |-> (req_sid >= last_sid));             // R6
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_blk)
            && $stable(req_sid) && $stable(req_mask)));                  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                 // R8
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_mask & served) == '0));                      // R9
    AST_ALL_SERVED: assert property (@(posedge clk) disable iff (rst)
        done |-> (served == cap_mask));                                  // R9
endmodule

bind swp_coalescer swc_checker #(
    .NUM_THR(NUM_THR), .SID_W(SID_W), .BLK_W(BLK_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sid(in_sid), .in_mask(in_mask), .req_valid(req_valid),
    .req_ready(req_ready), .req_blk(req_blk), .req_sid(req_sid),
    .req_mask(req_mask), .done(done)
);

// File: tb/swp_coalescer_bench.sv
`timescale 1ns/1ps
module swp_coalescer_bench;
    localparam int N  = 32;
    localparam int AW = 32;
    localparam int SW = 5;
    localparam int BW = 30;
    localparam int CW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [N*AW-1:0] in_addr = '0;
    logic [N*SW-1:0] in_sid = '0;
    logic [N-1:0]    in_mask = '0;
    logic            req_valid;
    logic            req_ready = 1'b0;
    logic [BW-1:0]   req_blk;
    logic [SW-1:0]   req_sid;
    logic [N-1:0]    req_mask;
    logic            done;
    logic [CW-1:0]   done_count;

    always #4 clk = ~clk;

    swp_coalescer u_swp_coalescer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_sid(in_sid), .in_mask(in_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_blk(req_blk),
        .req_sid(req_sid), .req_mask(req_mask), .done(done),
        .done_count(done_count)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_all();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    logic [BW-1:0] q_blk[$];
    logic [SW-1:0] q_sid[$];
    logic [N-1:0]  q_mask[$];
    bit  busy_m  = 0;
    int  done_cd = 0;
    int  exp_cnt = 0;
    int  issued  = 0;
    bit  monitor_on = 0;

    task automatic build_queue();
        logic [N-1:0] left;
        q_blk.delete(); q_sid.delete(); q_mask.delete();
        left = in_mask;
        for (int s = 0; s < 32; s++) begin
            for (int i = 0; i < N; i++) begin
                if (left[i] && in_sid[i*SW +: SW] == s[SW-1:0]) begin
                    logic [BW-1:0] b;
                    logic [N-1:0]  m;
                    b = in_addr[i*AW + 2 +: BW];
                    m = '0;
                    for (int j = i; j < N; j++) begin
                        if (left[j] && in_sid[j*SW +: SW] == s[SW-1:0]
                            && in_addr[j*AW + 2 +: BW] == b) begin
                            m[j] = 1'b1;
                        end
                    end
                    left = left & ~m;
                    q_blk.push_back(b);
                    q_sid.push_back(s[SW-1:0]);
                    q_mask.push_back(m);
                end
            end
        end
        exp_cnt = q_blk.size();
    endtask

    always @(negedge clk) begin
        if (monitor_on) begin
            if (done_cd == 1) busy_m = 0;
            // R1: ready whenever idle
            check(in_ready == !busy_m, "R1 in_ready", in_ready, !busy_m);
            check(req_valid == (busy_m && q_blk.size() > 0), "R1 req_valid",
                  req_valid, busy_m && q_blk.size() > 0);
            // R8: done pulse timing and count
            check(done == (done_cd == 1), "R8 done", done, done_cd == 1);
            if (done_cd == 1)
                check(done_count == CW'(issued), "R8 done_count", done_count, issued);
            if (done_cd > 0) done_cd--;
            if (req_valid && busy_m && q_blk.size() > 0) begin
                // R2, R3, R4, R6: request contents and order
                check(req_blk == q_blk[0], "R2 req_blk", req_blk, q_blk[0]);
                check(req_sid == q_sid[0], "R6 req_sid", req_sid, q_sid[0]);
                check(req_mask == q_mask[0], "R3 req_mask", req_mask, q_mask[0]);
                if (req_ready) begin
                    void'(q_blk.pop_front()); void'(q_sid.pop_front()); void'(q_mask.pop_front());
                    issued++;
                    if (q_blk.size() == 0) done_cd = 1;
                end
            end
            if (in_valid && in_ready) begin
                build_queue();
                issued  = 0;
                busy_m  = 1;
                if (q_blk.size() == 0) done_cd = 2;
            end
        end
    end

    // ---------------- consumer ----------------
    int rdy_mode = 0;
    always @(posedge clk) begin
        #1;
        if (rdy_mode == 0) req_ready = 1'b1;
        else req_ready = (($urandom % 3) != 0);
    end

    // ---------------- stimulus ----------------
    task automatic run_warp();
        int guard;
        @(posedge clk); #1;
        in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        guard = 0;
        forever begin
            @(negedge clk);
            if (done) break;
            guard++;
            if (guard > 400) begin
                check(0, "R8 done never seen", 0, 1);
                break;
            end
        end
    endtask

    task automatic clear_inputs();
        in_addr = '0; in_sid = '0; in_mask = '0;
    endtask

    task automatic set_thr(input int t, input logic [AW-1:0] a, input logic [SW-1:0] s);
        in_addr[t*AW +: AW] = a;
        in_sid[t*SW +: SW]  = s;
        in_mask[t] = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
        check(req_valid == 1'b0, "R10 req_valid", req_valid, 0);
        check(done == 1'b0, "R10 done", done, 0);
        monitor_on = 1;

        // R3/R4: one subwarp, 0x00 0x04 0x07 0x09 -> 3 requests
        clear_inputs();
        set_thr(0, 32'h00, 0); set_thr(1, 32'h04, 0); set_thr(2, 32'h07, 0); set_thr(3, 32'h09, 0);
        run_warp();
        check(done_count == 3, "R3 one-subwarp count", done_count, 3);

        // R4: same addresses split into ids 0,0,1,1 -> 4 requests
        clear_inputs();
        set_thr(0, 32'h00, 0); set_thr(1, 32'h04, 0); set_thr(2, 32'h07, 1); set_thr(3, 32'h09, 1);
        run_warp();
        check(done_count == 4, "R4 split-subwarp count", done_count, 4);

        // R4: same block in two subwarps -> two requests
        clear_inputs();
        set_thr(0, 32'h40, 3); set_thr(1, 32'h41, 2);
        run_warp();
        check(done_count == 2, "R4 same block two ids", done_count, 2);

        // R3: whole warp on one block
        clear_inputs();
        for (int t = 0; t < N; t++) set_thr(t, 32'h100 + (t % 4), 0);
        run_warp();
        check(done_count == 1, "R3 full merge", done_count, 1);

        // R9: all distinct blocks under backpressure, R7 held
        rdy_mode = 1;
        clear_inputs();
        for (int t = 0; t < N; t++) set_thr(t, 32'(t * 8), 0);
        run_warp();
        check(done_count == 32, "R9 all distinct", done_count, 32);

        // R8: empty warp
        clear_inputs();
        run_warp();
        check(done_count == 0, "R8 empty warp", done_count, 0);

        // R5/R6: descending ids, inactive threads carry colliding addresses
        clear_inputs();
        for (int t = 0; t < N; t++) set_thr(t, 32'h20 + 32'(t % 2) * 4, SW'(31 - t));
        for (int t = 0; t < N; t += 3) in_mask[t] = 1'b0;
        run_warp();
        check(done_count == 21, "R5 inactive skipped", done_count, 21);

        // mixed random warps
        for (int w = 0; w < 40; w++) begin
            rdy_mode = w % 2;
            clear_inputs();
            for (int t = 0; t < N; t++)
                set_thr(t, 32'($urandom % 48), SW'((w < 20) ? ($urandom % 4) : ($urandom % 32)));
            in_mask = $urandom;
            run_warp();
        end

        repeat (5) @(negedge clk);
        finish_all();
    end

    initial begin
        #(8 * 150000);
        check(0, "watchdog expired", 0, 1);
        finish_all();
    end
endmodule